// File: doc/BRIEF.md
# Triggered Dual-Polarization Capture Packetizer

This block records a burst of raw 12-bit samples from both polarizations of one antenna when a trigger arrives. Capture runs at the full sample rate: every cycle with a valid sample pair stores one memory word. Once the configured number of sample pairs is stored, the block reads the memory back at whatever pace the downstream side accepts. It frames the data into packets and sends them out as a byte stream.

Each packet starts with a 10-byte header: a 16-bit antenna number, then a 64-bit time tag. A payload of 3 bytes per sample pair follows, with X and Y interleaved and packed tightly. The stream carries start and end markers and uses a ready/valid handshake. The capture depth and the packet size are parameters. The full-size instance uses 400 sample pairs per packet, which gives 1200 payload bytes. A small depth lets a simulation cover several packets.

Top module: `tcp_raw_capture_packetizer`

## Requirements
- R1: After reset, `out_valid` and `busy` are low.
- R2: A trigger seen while `busy` is low starts a capture. The capture stores the next CAP_DEPTH cycles in which `adc_valid` is high, counting from the cycle after the trigger. Cycles with `adc_valid` low are skipped.
- R3: `out_valid` stays low while a capture is filling. Readout starts only once all CAP_DEPTH pairs are stored.
- R4: One capture yields CAP_DEPTH/PKT_SAMPLES packets. Each packet is 10 + 3*PKT_SAMPLES bytes long. `out_sop` is high only on its first byte and `out_eop` only on its last byte.
- R5: Header bytes 0 and 1 carry `ant_id`, most significant byte first. `ant_id` is sampled when readout starts.
- R6: Header bytes 2 to 9 carry the 64-bit time tag, most significant byte first. The tag of the first packet is the index of the first stored sample. Indices count cycles with `adc_valid` high since reset, starting at 0. Each later packet's tag is larger by PKT_SAMPLES.
- R7: Each stored pair emits three payload bytes in capture order: X[11:4], then {X[3:0], Y[11:8]}, then Y[7:0].
- R8: A trigger that arrives while `busy` is high has no effect. It neither restarts the capture nor queues a second one.
- R9: `busy` rises in the cycle after an accepted trigger. It falls in the cycle after the last byte of the last packet is accepted.
- R10: While `out_valid` is high and `out_ready` is low, `out_data`, `out_sop` and `out_eop` hold their values and no byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Capture trigger |
| adc_valid | input | 1 | A sample pair is present this cycle |
| adc_x | input | 12 | X polarization sample |
| adc_y | input | 12 | Y polarization sample |
| ant_id | input | 16 | Antenna number placed in headers |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte valid |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| out_ready | input | 1 | Downstream accepts a byte |
| busy | output | 1 | Capture or readout in progress |

## Verification
One capture is run with gaps in `adc_valid`. A design that counted clock cycles instead of valid samples, or that stored the trigger-cycle sample, would emit a wrong time tag and shifted payload. Extra triggers are fired both mid-fill and mid-readout. A design that restarted would scramble the payload, and one that queued the trigger would raise `busy` again after the last byte. The downstream side applies both random and heavy backpressure. This exposes a design that drops or changes a held byte, or lets `busy` fall before the final byte leaves. Packets are checked at the `out_eop` boundary and across the wrap of the time-tag increment.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
    localparam int SAMPLE_W  = 12;
    localparam int TAG_W     = 64;
    localparam int ANT_W     = 16;
    localparam int HDR_BYTES = 2 + TAG_W / 8;
    localparam int WORD_W    = 2 * SAMPLE_W;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_FILL = 1'b1
    } cap_state_e;
endpackage

// File: rtl/tcp_stamp_counter.sv
module tcp_stamp_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] count
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (adv) count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/tcp_capture_ram.sv
module tcp_capture_ram #(
    parameter int DEPTH = 800,
    parameter int WIDTH = 24,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    assert_wr_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (32'(waddr) < DEPTH));
endmodule

// File: rtl/tcp_framer.sv
module tcp_framer
    import tcp_pkg::*;
#(
    parameter int PKT_SAMPLES = 400,
    parameter int NUM_PKTS    = 2,
    parameter int AW          = 10,
    localparam int SIDX_W     = $clog2(PKT_SAMPLES) + 1,
    localparam int PKT_W      = $clog2(NUM_PKTS) + 1,
    localparam int PKT_BYTES  = HDR_BYTES + 3 * PKT_SAMPLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TAG_W-1:0]  start_tag,
    input  logic [ANT_W-1:0]  ant_id,
    output logic [AW-1:0]     rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic [7:0]        out_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    input  logic              out_ready,
    output logic              busy
);
    typedef struct packed {
        logic              active;
        logic              in_hdr;
        logic [3:0]        hidx;
        logic [SIDX_W-1:0] sidx;
        logic [1:0]        sub;
        logic [PKT_W-1:0]  pkt;
        logic [AW-1:0]     addr;
        logic [TAG_W-1:0]  tag;
        logic [ANT_W-1:0]  ant;
        logic [7:0]        data;
        logic              valid;
        logic              sop;
        logic              eop;
    } fr_t;

    fr_t        fr_d, fr_q;
    logic [7:0] hbyte;
    logic       load;

    always_comb begin
        hbyte = 8'h00;
        if (fr_q.hidx == 4'd0) hbyte = fr_q.ant[15:8];
        if (fr_q.hidx == 4'd1) hbyte = fr_q.ant[7:0];
        for (int i = 0; i < TAG_W / 8; i++) begin
            if (fr_q.hidx == 4'(i + 2)) hbyte = fr_q.tag[TAG_W-1-8*i -: 8];
        end
    end

    always_comb begin
        fr_d = fr_q;
        load = !fr_q.valid || out_ready;
        if (load) begin
            fr_d.valid = 1'b0;
            fr_d.sop   = 1'b0;
            fr_d.eop   = 1'b0;
            if (fr_q.active) begin
                fr_d.valid = 1'b1;
                if (fr_q.in_hdr) begin
                    fr_d.data = hbyte;
                    fr_d.sop  = (fr_q.hidx == 4'd0);
                    if (fr_q.hidx == 4'(HDR_BYTES - 1)) begin
                        fr_d.in_hdr = 1'b0;
                        fr_d.sidx   = '0;
                        fr_d.sub    = 2'd0;
                    end else begin
                        fr_d.hidx = fr_q.hidx + 4'd1;
                    end
                end else begin
                    case (fr_q.sub)
                        2'd0:    fr_d.data = rd_data[23:16];
                        2'd1:    fr_d.data = rd_data[15:8];
                        default: fr_d.data = rd_data[7:0];
                    endcase
                    if (fr_q.sub == 2'd2) begin
                        fr_d.sub  = 2'd0;
                        fr_d.addr = fr_q.addr + 1'b1;
                        if (fr_q.sidx == SIDX_W'(PKT_SAMPLES - 1)) begin
                            fr_d.eop    = 1'b1;
                            fr_d.in_hdr = 1'b1;
                            fr_d.hidx   = 4'd0;
                            fr_d.pkt    = fr_q.pkt + 1'b1;
                            fr_d.tag    = fr_q.tag + TAG_W'(PKT_SAMPLES);
                            if (fr_q.pkt == PKT_W'(NUM_PKTS - 1)) fr_d.active = 1'b0;
                        end else begin
                            fr_d.sidx = fr_q.sidx + 1'b1;
                        end
                    end else begin
                        fr_d.sub = fr_q.sub + 2'd1;
                    end
                end
            end
        end
        if (start) begin
            fr_d.active = 1'b1;
            fr_d.in_hdr = 1'b1;
            fr_d.hidx   = 4'd0;
            fr_d.pkt    = '0;
            fr_d.addr   = '0;
            fr_d.tag    = start_tag;
            fr_d.ant    = ant_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign rd_addr   = fr_q.addr;
    assign out_data  = fr_q.data;
    assign out_valid = fr_q.valid;
    assign out_sop   = fr_q.sop;
    assign out_eop   = fr_q.eop;
    assign busy      = fr_q.active || fr_q.valid;

    // byte counter used only by the packet length check
    logic [15:0] len_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) len_cnt_q <= '0;
        else if (out_valid && out_ready) len_cnt_q <= out_sop ? 16'd1 : len_cnt_q + 16'd1;
    end

    assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

    assert_packet_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |-> (len_cnt_q == 16'(PKT_BYTES - 1)));

    assert_sop_not_eop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> !out_eop);
endmodule

// File: rtl/tcp_raw_capture_packetizer.sv
module tcp_raw_capture_packetizer
    import tcp_pkg::*;
#(
    parameter int PKT_SAMPLES = 400,
    parameter int CAP_DEPTH   = 800,
    localparam int NUM_PKTS   = CAP_DEPTH / PKT_SAMPLES,
    localparam int AW         = $clog2(CAP_DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig,
    input  logic        adc_valid,
    input  logic [11:0] adc_x,
    input  logic [11:0] adc_y,
    input  logic [15:0] ant_id,
    output logic [7:0]  out_data,
    output logic        out_valid,
    output logic        out_sop,
    output logic        out_eop,
    input  logic        out_ready,
    output logic        busy
);
    typedef struct packed {
        cap_state_e       state;
        logic [AW-1:0]    wptr;
        logic [TAG_W-1:0] tag;
    } cap_t;

    cap_t              cap_d, cap_q;
    logic [TAG_W-1:0]  stamp;
    logic [TAG_W-1:0]  start_tag;
    logic              start;
    logic              we;
    logic              fr_busy;
    logic [AW-1:0]     rd_addr;
    logic [WORD_W-1:0] rd_data;

    tcp_stamp_counter #(.W(TAG_W)) u_stamp (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adc_valid),
        .count (stamp)
    );

    always_comb begin
        cap_d     = cap_q;
        start     = 1'b0;
        we        = 1'b0;
        start_tag = cap_q.tag;
        case (cap_q.state)
            CAP_IDLE: begin
                if (trig && !fr_busy) begin
                    cap_d.state = CAP_FILL;
                    cap_d.wptr  = '0;
                end
            end
            CAP_FILL: begin
                if (adc_valid) begin
                    we = 1'b1;
                    if (cap_q.wptr == '0) begin
                        cap_d.tag = stamp;
                        start_tag = stamp;
                    end
                    if (cap_q.wptr == AW'(CAP_DEPTH - 1)) begin
                        start       = 1'b1;
                        cap_d.state = CAP_IDLE;
                    end else begin
                        cap_d.wptr = cap_q.wptr + 1'b1;
                    end
                end
            end
            default: cap_d.state = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    tcp_capture_ram #(.DEPTH(CAP_DEPTH), .WIDTH(WORD_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (cap_q.wptr),
        .wdata ({adc_x, adc_y}),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    tcp_framer #(.PKT_SAMPLES(PKT_SAMPLES), .NUM_PKTS(NUM_PKTS), .AW(AW)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_tag (start_tag),
        .ant_id    (ant_id),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_ready (out_ready),
        .busy      (fr_busy)
    );

    assign busy = (cap_q.state == CAP_FILL) || fr_busy;

    assert_trig_accepted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !busy) |=> busy);

    assert_no_output_in_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.state == CAP_FILL) |-> !out_valid);

    assert_trig_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.state == CAP_FILL && trig && !adc_valid) |=> (cap_q.state == CAP_FILL && $stable(cap_q.wptr)));
endmodule

// File: tb/tcp_raw_capture_packetizer_bench.sv
module tcp_raw_capture_packetizer_bench;
    localparam int PKT   = 4;
    localparam int DEPTH = 12;
    localparam int NPK   = DEPTH / PKT;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        trig = 1'b0, adc_valid = 1'b0, out_ready = 1'b0;
    logic [11:0] adc_x = '0, adc_y = '0;
    logic [15:0] ant_id = 16'h0000;
    logic [7:0]  out_data;
    logic        out_valid, out_sop, out_eop, busy;

    tcp_raw_capture_packetizer #(.PKT_SAMPLES(PKT), .CAP_DEPTH(DEPTH)) u_tcp_raw_capture_packetizer (
        .clk(clk), .rst_n(rst_n), .trig(trig), .adc_valid(adc_valid),
        .adc_x(adc_x), .adc_y(adc_y), .ant_id(ant_id),
        .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_ready(out_ready), .busy(busy)
    );

    int          n_chk = 0, n_fail = 0;
    longint      cyc = 0, samp_cnt = 0;
    logic [11:0] exp_q[$];
    longint      cap_q[$];
    bit          capturing = 0, mb = 0, trig_req = 0;
    int          vmode = 0, rmode = 0;
    logic [7:0]  lfsr = 8'h5A;
    bit          stall_pend = 0;
    logic [9:0]  stall_val;

    function automatic logic [11:0] fx(longint i);
        return 12'(i * 37 + 5);
    endfunction
    function automatic logic [11:0] fy(longint i);
        return 12'(i * 91) ^ 12'hA5C;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // driver side of the scoreboard: turn one finished capture into expected bytes
    function automatic void build_expected();
        longint first = cap_q[0];
        for (int p = 0; p < NPK; p++) begin
            logic [63:0] tag = 64'(first + longint'(p * PKT));
            exp_q.push_back({2'd0, 1'b1, 1'b0, ant_id[15:8]});
            exp_q.push_back({2'd0, 1'b0, 1'b0, ant_id[7:0]});
            for (int b = 0; b < 8; b++) exp_q.push_back({2'd1, 2'b00, tag[63-8*b -: 8]});
            for (int s = 0; s < PKT; s++) begin
                logic [11:0] x = fx(cap_q[p*PKT+s]);
                logic [11:0] y = fy(cap_q[p*PKT+s]);
                exp_q.push_back({2'd2, 2'b00, x[11:4]});
                exp_q.push_back({2'd2, 2'b00, x[3:0], y[11:8]});
                exp_q.push_back({2'd2, 1'b0, (s == PKT - 1), y[7:0]});
            end
        end
        cap_q.delete();
    endfunction

    // monitor and stimulus, both away from the active edge
    always @(negedge clk) begin
        bit clear_busy;
        logic [11:0] e;
        string rq;
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
        if (!rst_n) begin
            adc_valid = 1'b0; trig = 1'b0; out_ready = 1'b0;
        end else begin
            chk(busy == mb, "R9", "busy", busy, mb);
            if (stall_pend)
                chk(out_valid && {out_data, out_sop, out_eop} == stall_val, "R10", "held byte",
                    {out_valid, out_data, out_sop, out_eop}, {1'b1, stall_val});
            if (capturing) chk(!out_valid, "R3", "out_valid while filling", out_valid, 0);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (rmode)
                0:       out_ready = 1'b1;
                1:       out_ready = lfsr[0] | lfsr[1];
                default: out_ready = (lfsr[2:0] == 3'd0);
            endcase
            clear_busy = 0;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) chk(0, "R4", "unexpected byte", out_data, 0);
                else begin
                    e = exp_q.pop_front();
                    rq = (e[11:10] == 2'd0) ? "R5" : (e[11:10] == 2'd1) ? "R6" : "R2 R7";
                    chk(out_data == e[7:0], rq, "byte", out_data, e[7:0]);
                    chk({out_sop, out_eop} == e[9:8], "R4", "sop/eop", {out_sop, out_eop}, e[9:8]);
                    if (exp_q.size() == 0 && !capturing) clear_busy = 1;
                end
            end
            stall_pend = out_valid && !out_ready;
            stall_val  = {out_data, out_sop, out_eop};
            trig = trig_req;
            trig_req = 0;
            adc_valid = (vmode == 0) ? 1'b1 : (cyc % 3 != 1);
            adc_x = fx(samp_cnt);
            adc_y = fy(samp_cnt);
            if (adc_valid) begin
                if (capturing) begin
                    cap_q.push_back(samp_cnt);
                    if (cap_q.size() == DEPTH) begin
                        capturing = 0;
                        build_expected();
                    end
                end
                samp_cnt++;
            end
            if (trig && !mb) begin mb = 1; capturing = 1; end
            if (clear_busy) mb = 0;
        end
    end

    task automatic wait_idle();
        while (mb || trig_req) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
        chk(!busy, "R1", "busy after reset", busy, 0);
        rst_n = 1'b1;

        // continuous samples, free-flowing output, extra triggers mid-fill and mid-readout (R8)
        ant_id = 16'h1A2B; vmode = 0; rmode = 0;
        repeat (3) @(posedge clk);
        trig_req = 1;
        repeat (6) @(posedge clk);
        trig_req = 1;
        while (exp_q.size() < 6) @(posedge clk);
        trig_req = 1;
        wait_idle();

        // gapped samples and random backpressure (R2, R6 tag counts valid samples only)
        ant_id = 16'hC0DE; vmode = 1; rmode = 1;
        repeat (5) @(posedge clk);
        trig_req = 1;
        repeat (4) @(posedge clk);
        trig_req = 1;
        wait_idle();

        // heavy backpressure (R10) with a trigger during the stalled readout (R8)
        ant_id = 16'h0007; vmode = 0; rmode = 2;
        trig_req = 1;
        while (exp_q.size() < 30) @(posedge clk);
        trig_req = 1;
        wait_idle();

        // ignored triggers left nothing pending (R8)
        repeat (20) begin
            @(negedge clk);
            #1;
            chk(!out_valid && !busy && exp_q.size() == 0, "R8", "idle after ignored triggers",
                {out_valid, busy}, 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule